// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block turns the output of an infrared demodulator into a stream of run-length bytes. The raw line is synchronised to the base clock and optionally inverted, so that the "active" level is always 1 inside the block. It is then sampled once every `DIV` base clocks. A noise filter removes short level changes, and every stretch of constant filtered level becomes one byte. Bit 7 of the byte is the level and bits 6:0 hold the number of samples minus one. A run longer than 128 samples is split into several bytes of the same level.

A packet starts at the first accepted active level. The packet closes after a programmable number of consecutive inactive samples: `(idle_thr + 1) × IDLE_SCALE`. At that moment the trailing inactive run is flushed as a byte, and an end-of-packet pulse is raised in the same cycle. Nothing more is emitted until the next accepted active level. Capture runs only while both the module enable and the receive enable are high. Dropping either one clears all capture state.

The byte output is a valid strobe with no ready. The source is a real-time line that cannot be paused, so there is no back-pressure. The consumer must take every strobe, and strobes are at least `DIV` clocks apart.

Top module: `ir_rle_encoder`

## Requirements
- R1: Samples are taken once every `DIV` base clocks while both enables are high. Each output strobe lasts exactly one clock and follows a sample tick by two clocks. Two bytes emitted at samples `k` apart appear `k × DIV` clocks apart.
- R2: Each output byte carries the run level in bit 7 (1 = active) and the run length in bits 6:0 as the sample count minus one.
- R3: With `invert` = 1, a low raw line is the active level. With `invert` = 0, a high raw line is active.
- R4: A level change that lasts `noise_thr` samples or fewer is discarded, and its samples count toward the surrounding run. A change that lasts `noise_thr + 1` samples or more is accepted, and run lengths are preserved.
- R5: A run of more than 128 samples is emitted as bytes with bits 6:0 = 127 (128 samples each), followed by one byte for the remainder.
- R6: After `(idle_thr + 1) × IDLE_SCALE` consecutive inactive samples, `out_eop` pulses together with `out_valid`. The byte carries the trailing inactive run: bit 7 = 0 and length equal to that sample count, when it is 128 or less.
- R7: Before the first packet and after end of packet, inactive samples produce no bytes. A packet starts only when an active level is accepted by the filter.
- R8: While `mod_en` or `rx_en` is low, `out_valid` and `out_eop` stay low and all capture state is cleared.
- R9: During and right after reset, `out_valid` and `out_eop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Raw demodulator line (asynchronous) |
| mod_en | input | 1 | Module enable |
| rx_en | input | 1 | Receive enable |
| invert | input | 1 | 1 = treat a low raw line as active |
| noise_thr | input | NOISE_W | Longest level change, in samples, that is discarded |
| idle_thr | input | IDLE_W | Idle time code; idle = (idle_thr+1)×IDLE_SCALE samples |
| out_valid | output | 1 | One-clock strobe: out_byte holds a run |
| out_byte | output | 8 | {level, samples−1} |
| out_eop | output | 1 | End-of-packet pulse, coincides with the final out_valid |

## Verification
A byte strobe appears two clocks after the sample tick that completes its run: one register for the filter stage and one for the output. Raw input edges also pass two synchroniser flops first. This latency is the same for every edge, so the bench drives each level for a whole number of sample periods and compares run lengths rather than absolute times. Spacing is checked instead. Bytes whose runs end `k` samples apart must arrive exactly `k × DIV` clocks apart, and the end-of-packet strobe must come a full idle time after the last active run ends. A monitor samples the outputs on the falling edge, so no check depends on the order of processes at the rising edge.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
  localparam int RUN_LEN_W = 7;
  localparam int RUN_MAX   = 1 << RUN_LEN_W;

  typedef struct packed {
    logic                 active;
    logic [RUN_LEN_W-1:0] len_m1;
  } run_byte_t;
endpackage

// File: rtl/ir_rle_sync.sv
module ir_rle_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ir_rle_tick.sv
module ir_rle_tick #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/ir_rle_filter.sv
module ir_rle_filter #(
  parameter int NOISE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic               smp,
  input  logic [NOISE_W-1:0] nthr,
  output logic               lvl
);
  // pend counts consecutive samples that disagree with the accepted level
  logic [NOISE_W:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl  <= 1'b0;
      pend <= '0;
    end else if (clr) begin
      lvl  <= 1'b0;
      pend <= '0;
    end else if (step) begin
      if (smp == lvl) begin
        pend <= '0;
      end else if (pend >= {1'b0, nthr}) begin
        lvl  <= ~lvl;
        pend <= '0;
      end else begin
        pend <= pend + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ir_rle_packer.sv
module ir_rle_packer
  import ir_rle_pkg::*;
#(
  parameter int IDLE_SCALE = 128,
  parameter int IDLE_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              lvl,
  input  logic [IDLE_W-1:0] idle_thr,
  output logic              out_valid,
  output run_byte_t         out_byte,
  output logic              out_eop
);
  localparam int IW = IDLE_W + $clog2(IDLE_SCALE) + 1;
  localparam int CW = RUN_LEN_W + 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(RUN_MAX);

  logic          in_pkt, cur;
  logic [CW-1:0] cnt, cnt_m1;
  logic [IW-1:0] idl, idl_inc, limit;

  assign limit   = IW'((32'(idle_thr) + 32'd1) * 32'(IDLE_SCALE));
  assign idl_inc = idl + 1'b1;
  assign cnt_m1  = cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt    <= 1'b0;
      cur       <= 1'b0;
      cnt       <= '0;
      idl       <= '0;
      out_valid <= 1'b0;
      out_eop   <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_eop   <= 1'b0;
      if (clr) begin
        in_pkt <= 1'b0;
        cur    <= 1'b0;
        cnt    <= '0;
        idl    <= '0;
      end else if (step) begin
        if (!in_pkt) begin
          if (lvl) begin
            in_pkt <= 1'b1;
            cur    <= 1'b1;
            cnt    <= CW'(1);
            idl    <= '0;
          end
        end else if (!lvl && idl_inc == limit) begin
          // close the packet: flush the trailing quiet run with this sample
          out_valid       <= 1'b1;
          out_eop         <= 1'b1;
          out_byte.active <= 1'b0;
          out_byte.len_m1 <= (cnt == CNT_MAX) ? '1 : cnt[RUN_LEN_W-1:0];
          in_pkt          <= 1'b0;
          cur             <= 1'b0;
          cnt             <= '0;
          idl             <= '0;
        end else begin
          idl <= lvl ? '0 : idl_inc;
          if (lvl == cur) begin
            if (cnt == CNT_MAX) begin
              out_valid       <= 1'b1;
              out_byte.active <= cur;
              out_byte.len_m1 <= '1;
              cnt             <= CW'(1);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            out_valid       <= 1'b1;
            out_byte.active <= cur;
            out_byte.len_m1 <= cnt_m1[RUN_LEN_W-1:0];
            cur             <= lvl;
            cnt             <= CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/ir_rle_encoder.sv
module ir_rle_encoder
  import ir_rle_pkg::*;
#(
  parameter int DIV        = 64,
  parameter int IDLE_SCALE = 128,
  parameter int NOISE_W    = 6,
  parameter int IDLE_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ir_in,
  input  logic                 mod_en,
  input  logic                 rx_en,
  input  logic                 invert,
  input  logic [NOISE_W-1:0]   noise_thr,
  input  logic [IDLE_W-1:0]    idle_thr,
  output logic                 out_valid,
  output logic [RUN_LEN_W:0]   out_byte,
  output logic                 out_eop
);
  logic      en, synced, act, tick, tick_d, flt;
  run_byte_t pk_byte;

  assign en = mod_en & rx_en;

  ir_rle_sync u_sync (.clk(clk), .rst_n(rst_n), .d(ir_in), .q(synced));

  assign act = synced ^ invert;

  ir_rle_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick)
  );

  ir_rle_filter #(.NOISE_W(NOISE_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .clr(!en), .step(tick),
    .smp(act), .nthr(noise_thr), .lvl(flt)
  );

  // filter result settles one clock after the tick; packer steps then
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_d <= 1'b0;
    else        tick_d <= tick & en;
  end

  ir_rle_packer #(.IDLE_SCALE(IDLE_SCALE), .IDLE_W(IDLE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(!en), .step(tick_d), .lvl(flt),
    .idle_thr(idle_thr), .out_valid(out_valid), .out_byte(pk_byte),
    .out_eop(out_eop)
  );

  assign out_byte = pk_byte;
endmodule

// File: rtl/ir_rle_chk.sv
module ir_rle_chk (
  input logic clk,
  input logic rst_n,
  input logic mod_en,
  input logic rx_en,
  input logic tick,
  input logic out_valid,
  input logic lvl_bit,
  input logic out_eop
);
  // R6
  eop_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |-> (out_valid && !lvl_bit));

  // R1
  tick_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(tick, 2));

  // R1
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_en && rx_en) |=> (!out_valid && !out_eop));
endmodule

bind ir_rle_encoder ir_rle_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .rx_en(rx_en), .tick(tick),
  .out_valid(out_valid), .lvl_bit(out_byte[7]), .out_eop(out_eop)
);

// File: tb/sim_ir_rle_encoder.sv
module sim_ir_rle_encoder;
  localparam int DIV   = 4;
  localparam int SCALE = 16;
  localparam int NVEC  = 6;

  typedef struct packed {
    logic [5:0] nthr;
    logic [7:0] ithr;
    logic       inv;
    logic [8:0] s0, s1, s2;
    logic [2:0] nexp;
    logic [7:0] e0, e1, e2, e3;
  } vec_t;

  // segments: s0 active, s1 quiet, s2 active (0 = skip), then quiet until eop
  localparam vec_t VECS [NVEC] = '{
    '{6'd0, 8'd0, 1'b0, 9'd5,   9'd3,  9'd2, 3'd4, 8'h84, 8'h02, 8'h81, 8'h0F},
    '{6'd0, 8'd0, 1'b1, 9'd10,  9'd0,  9'd0, 3'd2, 8'h89, 8'h0F, 8'h00, 8'h00},
    '{6'd2, 8'd0, 1'b0, 9'd6,   9'd2,  9'd4, 3'd2, 8'h8B, 8'h0F, 8'h00, 8'h00},
    '{6'd0, 8'd0, 1'b0, 9'd130, 9'd0,  9'd0, 3'd3, 8'hFF, 8'h81, 8'h0F, 8'h00},
    '{6'd0, 8'd1, 1'b0, 9'd3,   9'd20, 9'd4, 3'd4, 8'h82, 8'h13, 8'h83, 8'h1F},
    '{6'd1, 8'd0, 1'b0, 9'd5,   9'd2,  9'd5, 3'd4, 8'h84, 8'h01, 8'h84, 8'h0F}
  };

  logic clk = 1'b0, rst_n = 1'b0, ir_in = 1'b0, mod_en = 1'b0, rx_en = 1'b0;
  logic invert = 1'b0;
  logic [5:0] noise_thr = '0;
  logic [7:0] idle_thr = '0;
  logic out_valid, out_eop;
  logic [7:0] out_byte;

  int nchk = 0, nerr = 0, cyc = 0;
  int ngot = 0, neop = 0;
  logic [7:0] got [16];
  int t_got [16];

  always #5 clk = ~clk;

  ir_rle_encoder #(.DIV(DIV), .IDLE_SCALE(SCALE)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .mod_en(mod_en), .rx_en(rx_en),
    .invert(invert), .noise_thr(noise_thr), .idle_thr(idle_thr),
    .out_valid(out_valid), .out_byte(out_byte), .out_eop(out_eop)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (ngot < 16) begin
        got[ngot]   = out_byte;
        t_got[ngot] = cyc;
      end
      ngot = ngot + 1;
    end
    if (rst_n && out_eop) neop = neop + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic seg(input logic a, input int n);
    ir_in = a ^ invert;
    repeat (n * DIV) @(negedge clk);
  endtask

  function automatic string vtag(input int i);
    case (i)
      0: vtag = "R2 R6 vector0";
      1: vtag = "R3 vector1";
      2: vtag = "R4 glitch absorbed";
      3: vtag = "R5 long run";
      4: vtag = "R6 idle_thr=1";
      default: vtag = "R4 change accepted";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!out_valid && !out_eop, "R9 reset", {out_valid, out_eop}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!out_valid && !out_eop, "R9 after reset", {out_valid, out_eop}, 0);

    // R8: one enable low at a time, line toggles, nothing comes out
    mod_en = 1'b1; rx_en = 1'b0; ngot = 0; neop = 0;
    seg(1, 10); seg(0, 30);
    chk(ngot == 0 && neop == 0, "R8 rx_en low", ngot, 0);
    mod_en = 1'b0; rx_en = 1'b1; ngot = 0; neop = 0;
    seg(1, 10); seg(0, 30);
    chk(ngot == 0 && neop == 0, "R8 mod_en low", ngot, 0);

    // table of vectors
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      int lim;
      logic [7:0] ex;
      v = VECS[i];
      mod_en = 1'b0;
      invert = v.inv; noise_thr = v.nthr; idle_thr = v.ithr;
      ir_in = v.inv;
      repeat (4) @(negedge clk);
      mod_en = 1'b1;
      seg(0, 10);
      ngot = 0; neop = 0;
      lim = (int'(v.ithr) + 1) * SCALE;
      if (v.s0 != 0) seg(1, int'(v.s0));
      if (v.s1 != 0) seg(0, int'(v.s1));
      if (v.s2 != 0) seg(1, int'(v.s2));
      seg(0, lim + 40);
      // R7: nothing after end of packet
      chk(ngot == int'(v.nexp), {vtag(i), " R7 count"}, ngot, int'(v.nexp));
      for (int k = 0; k < int'(v.nexp); k++) begin
        case (k)
          0: ex = v.e0;
          1: ex = v.e1;
          2: ex = v.e2;
          default: ex = v.e3;
        endcase
        chk(got[k] == ex, {vtag(i), " R2 byte"}, int'(got[k]), int'(ex));
      end
      chk(neop == 1, {vtag(i), " R6 eop count"}, neop, 1);
      if (i == 0) begin
        chk(t_got[1] - t_got[0] == 3 * DIV, "R1 spacing", t_got[1] - t_got[0], 3 * DIV);
        chk(t_got[3] - t_got[2] == 15 * DIV, "R6 idle time", t_got[3] - t_got[2], 15 * DIV);
      end
    end

    // R4/R7: active blip of noise_thr samples from idle starts nothing
    mod_en = 1'b0; invert = 1'b0; noise_thr = 6'd2; idle_thr = 8'd0; ir_in = 1'b0;
    repeat (4) @(negedge clk);
    mod_en = 1'b1; seg(0, 10);
    ngot = 0; neop = 0;
    seg(1, 2); seg(0, 40);
    chk(ngot == 0 && neop == 0, "R4 R7 blip ignored", ngot, 0);
    // R4: noise_thr+1 samples is accepted
    ngot = 0; neop = 0;
    seg(1, 3); seg(0, 40);
    chk(ngot == 2, "R4 boundary count", ngot, 2);
    chk(got[0] == 8'h82, "R4 boundary byte", int'(got[0]), 8'h82);
    chk(neop == 1, "R4 boundary eop", neop, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule